// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital front end of a six-bit step attenuator. It takes either a serial word (a serial clock, a serial data line and a latch strobe) or a parallel word (six level inputs plus the same latch strobe). A mode input chooses which path is used. It drives a registered six-bit code to the analog section. The code is the attenuation in half-decibel steps, so bit 5 weighs 16 dB and bit 0 weighs 0.5 dB. It also drives a one-cycle strobe each time that code takes a new value.

All external control pins are asynchronous to the system clock and pass through multi-flop synchronisers. Edges of the serial clock and of the latch strobe are found on the synchronised copies. The single latch strobe has three roles, depending on the mode:
- It commits the shifted serial word on its rising edge.
- While it is high, it freezes the serial shift register.
- In parallel mode, its level chooses between a transparent path and a latched path.

Top module: `step_atten_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until the first update, `atten_code_o` is 6'b111111 (31.5 dB) and `code_updated_o` is 0, whatever the mode and parallel pins read.
- R2: With `mode_ser_i`=1 and `latch_en_i` low, each rising edge of `ser_clk_i` shifts `ser_data_i` into the code LSB side, so the first bit sent ends as bit 5. A rising edge of `latch_en_i` loads the last six bits shifted; earlier extra bits are lost.
- R3: While `latch_en_i` is high, serial clock edges and data are ignored and the shift register keeps its contents.
- R4: With `mode_ser_i`=0 and `latch_en_i` high, `atten_code_o` follows `par_word_i`.
- R5: With `mode_ser_i`=0 and `latch_en_i` low, changes on `par_word_i` do not change `atten_code_o`.
- R6: With `mode_ser_i`=0, a low-to-high transition of `latch_en_i` loads `par_word_i` into `atten_code_o`.
- R7: Switching `mode_ser_i` from 0 to 1 leaves `atten_code_o` unchanged; the next serial latch rising edge sets it.
- R8: `code_updated_o` is high for exactly one cycle each time `atten_code_o` changes value, and stays low when a load repeats the present value.
- R9: In serial mode `par_word_i` has no effect on `atten_code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_data_i | input | 1 | Serial data, MSB first |
| latch_en_i | input | 1 | Latch strobe: serial commit, shift freeze, parallel transparent/latched select |
| mode_ser_i | input | 1 | 1 = serial path, 0 = parallel path |
| par_word_i | input | CODE_W | Parallel attenuation word |
| atten_code_o | output | CODE_W | Registered attenuation code, half-dB units |
| code_updated_o | output | 1 | One-cycle pulse when the code changes |

## Verification
The assertions rely on the external pins holding each level for at least two system clock periods, so that no edge is lost in the synchronisers. They also rely on serial data being settled before the synchronised serial clock rises, and on `latch_en_i` never rising in the same synchronised cycle as a serial clock edge. The bench drives every pin from the falling system clock edge and holds each level for four cycles. It changes data only while the serial clock is low, and it raises the strobe only after the serial clock has returned low.

// File: rtl/atten_pkg.sv
package atten_pkg;

   // Default width of the attenuation control word (half-dB units)
   parameter int unsigned ATT_CODE_W = 6;

   // Control pins that share one synchroniser bank
   typedef struct packed {
      logic ser_clk;
      logic ser_data;
      logic latch_en;
      logic mode_ser;
   } ctl_t;

   localparam int unsigned CTL_W = $bits(ctl_t);

   // Idle levels: strobe and mode float high, serial lines low
   localparam ctl_t CTL_IDLE = '{ser_clk: 1'b0, ser_data: 1'b0, latch_en: 1'b1, mode_ser: 1'b1};

endpackage

// File: rtl/atten_sync_bank.sv
module atten_sync_bank #(
   parameter int unsigned   W       = 4,
   parameter int unsigned   STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [W-1:0]  d_i,
   output logic [W-1:0]  q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("atten_sync_bank: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("atten_sync_bank: W must be at least 1");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= RST_VAL;
            else         stage_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= RST_VAL;
            else         stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/atten_ser_shift.sv
module atten_ser_shift #(
   parameter int unsigned  W       = 6,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          ser_mode_i,
   input  logic          le_i,
   input  logic          sclk_i,
   input  logic          sdata_i,
   output logic [W-1:0]  shreg_o
);

   if (W < 2) begin : g_bad_width
      $error("atten_ser_shift: W must be at least 2");
   end

   logic          sclk_q;
   logic          sclk_rise;
   logic          shift_en;
   logic [W-1:0]  shreg_q;

   assign sclk_rise = sclk_i & ~sclk_q;
   assign shift_en  = ser_mode_i & ~le_i & sclk_rise;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sclk_q <= 1'b0;
      else         sclk_q <= sclk_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       shreg_q <= RST_VAL;
      else if (shift_en) shreg_q <= {shreg_q[W-2:0], sdata_i};
   end

   assign shreg_o = shreg_q;

   // R3: a high strobe freezes the shift register
   p_frozen_while_latched_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      le_i |=> $stable(shreg_q));

   // R9: parallel mode never disturbs the serial register
   p_idle_in_parallel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ser_mode_i |=> $stable(shreg_q));

endmodule

// File: rtl/atten_code_reg.sv
module atten_code_reg #(
   parameter int unsigned  W        = 6,
   parameter logic [W-1:0] RST_CODE = '1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          ser_mode_i,
   input  logic          le_i,
   input  logic [W-1:0]  shreg_i,
   input  logic [W-1:0]  par_i,
   output logic [W-1:0]  code_o,
   output logic          updated_o
);

   logic          le_q;
   logic          le_rise;
   logic          load_en;
   logic [W-1:0]  load_val;
   logic [W-1:0]  code_q;
   logic          upd_q;

   assign le_rise = le_i & ~le_q;

   always_comb begin
      if (ser_mode_i) begin
         load_en  = le_rise;
         load_val = shreg_i;
      end else begin
         load_en  = le_i;
         load_val = par_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) le_q <= 1'b1;
      else         le_q <= le_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_q <= RST_CODE;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= load_en && (load_val != code_q);
         if (load_en) code_q <= load_val;
      end
   end

   assign code_o    = code_q;
   assign updated_o = upd_q;

   // R2: serial commit takes the shift register
   p_serial_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ser_mode_i && le_i && !le_q) |=> (code_q == $past(shreg_i)));

   // R4: transparent parallel path
   p_direct_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ser_mode_i && le_i) |=> (code_q == $past(par_i)));

   // R5: latched parallel path holds
   p_latched_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ser_mode_i && !le_i) |=> $stable(code_q));

   // R8: strobe marks every change and nothing else
   p_pulse_on_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_q != $past(code_q)) |-> upd_q);
   p_pulse_only_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_q |-> (code_q != $past(code_q)));

endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
   parameter int unsigned CODE_W      = atten_pkg::ATT_CODE_W,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ser_clk_i,
   input  logic              ser_data_i,
   input  logic              latch_en_i,
   input  logic              mode_ser_i,
   input  logic [CODE_W-1:0] par_word_i,
   output logic [CODE_W-1:0] atten_code_o,
   output logic              code_updated_o
);

   import atten_pkg::*;

   localparam logic [CODE_W-1:0] MAX_CODE = '1;

   if (CODE_W < 2) begin : g_bad_code_w
      $error("step_atten_ctrl: CODE_W must be at least 2");
   end

   ctl_t              ctl_raw;
   ctl_t              ctl_s;
   logic [CTL_W-1:0]  ctl_s_vec;
   logic [CODE_W-1:0] par_s;
   logic [CODE_W-1:0] shreg;

   assign ctl_raw = '{ser_clk: ser_clk_i, ser_data: ser_data_i,
                      latch_en: latch_en_i, mode_ser: mode_ser_i};

   atten_sync_bank #(
      .W       (CTL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CTL_IDLE)
   ) ctl_sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (ctl_raw),
      .q_o    (ctl_s_vec)
   );
   assign ctl_s = ctl_t'(ctl_s_vec);

   atten_sync_bank #(
      .W       (CODE_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('0)
   ) par_sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (par_word_i),
      .q_o    (par_s)
   );

   atten_ser_shift #(
      .W       (CODE_W),
      .RST_VAL (MAX_CODE)
   ) shift_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ser_mode_i (ctl_s.mode_ser),
      .le_i       (ctl_s.latch_en),
      .sclk_i     (ctl_s.ser_clk),
      .sdata_i    (ctl_s.ser_data),
      .shreg_o    (shreg)
   );

   atten_code_reg #(
      .W        (CODE_W),
      .RST_CODE (MAX_CODE)
   ) code_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ser_mode_i (ctl_s.mode_ser),
      .le_i       (ctl_s.latch_en),
      .shreg_i    (shreg),
      .par_i      (par_s),
      .code_o     (atten_code_o),
      .updated_o  (code_updated_o)
   );

   // R1: reset value is maximum attenuation with no strobe
   p_reset_max_r1: assert property (@(posedge clk_i)
      !rst_ni |=> (atten_code_o == MAX_CODE && !code_updated_o));

   // R7: a mode change alone never moves the code
   p_mode_switch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(ctl_s.mode_ser) && !ctl_s.latch_en) |=> $stable(atten_code_o));

endmodule

// File: tb/step_atten_ctrl_tb_top.sv
`timescale 1ns/1ps
module step_atten_ctrl_tb_top;

   localparam int W = 6;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         sclk, sdata, le, mode;
   logic [W-1:0] par;
   logic [W-1:0] code;
   logic         upd;

   int tests  = 0;
   int fails  = 0;
   int pulses = 0;
   int exp_pulses = 0;
   logic [W-1:0] last_exp = '1;
   bit done = 0;

   logic [W-1:0] exp_code_q[$];
   string        exp_tag_q[$];

   always #10 clk = ~clk;

   step_atten_ctrl dut_i (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .ser_clk_i      (sclk),
      .ser_data_i     (sdata),
      .latch_en_i     (le),
      .mode_ser_i     (mode),
      .par_word_i     (par),
      .atten_code_o   (code),
      .code_updated_o (upd)
   );

   always @(negedge clk) if (rst_n && upd) pulses++;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Driver: push expected code; monitor compares once the pipeline settles
   task automatic expect_code(input logic [W-1:0] v, input string tag);
      if (v != last_exp) exp_pulses++;
      last_exp = v;
      exp_code_q.push_back(v);
      exp_tag_q.push_back(tag);
      wait (exp_code_q.size() == 0);
      idle(1);
   endtask

   // Monitor
   initial begin
      forever begin
         @(negedge clk);
         if (exp_code_q.size() > 0) begin
            idle(6);
            check(code == exp_code_q[0], exp_tag_q[0], code, exp_code_q[0]);
            void'(exp_code_q.pop_front());
            void'(exp_tag_q.pop_front());
         end
      end
   end

   task automatic set_le(input logic v);
      @(negedge clk); le = v; idle(4);
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); sdata = b; idle(4);
      sclk = 1'b1; idle(4);
      sclk = 1'b0; idle(4);
   endtask

   task automatic send_bits(input logic [15:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic check_pulses(input string tag);
      check(pulses == exp_pulses, tag, pulses, exp_pulses);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; sclk = 1'b0; sdata = 1'b0; le = 1'b1; mode = 1'b1; par = 6'h15;
      idle(5);
      check(code == 6'h3F, "R1 code in reset", code, 6'h3F);
      check(upd == 1'b0, "R1 strobe in reset", upd, 0);
      rst_n = 1'b1;
      idle(10);
      check(code == 6'h3F, "R1 code after reset", code, 6'h3F);
      check_pulses("R1 no strobe after reset");

      // R2: eight bits sent, last six kept, MSB first
      set_le(1'b0);
      send_bits(16'b11_101100, 8);
      set_le(1'b1);
      expect_code(6'h2C, "R2 serial commit");
      check_pulses("R8 one pulse per serial change");

      // R9: parallel word ignored in serial mode
      @(negedge clk); par = 6'h07; idle(4);
      expect_code(6'h2C, "R9 parallel ignored in serial");

      // R3: bits clocked with strobe high are ignored
      send_bits(16'b111, 3);
      set_le(1'b0);
      send_bits(16'b000, 3);
      set_le(1'b1);
      expect_code(6'h20, "R3 shifts frozen while strobe high");

      // R8: reloading the same value gives no pulse
      set_le(1'b0);
      send_bits(16'b100000, 6);
      set_le(1'b1);
      expect_code(6'h20, "R8 repeat value");
      check_pulses("R8 no pulse on repeat");

      // Boundary: all-zero code
      set_le(1'b0);
      send_bits(16'b000000, 6);
      set_le(1'b1);
      expect_code(6'h00, "R2 minimum code");

      // R4: direct parallel
      @(negedge clk); mode = 1'b0; idle(4);
      expect_code(6'h07, "R4 direct after mode change");
      @(negedge clk); par = 6'h3A;
      expect_code(6'h3A, "R4 direct follows word");
      check_pulses("R8 pulses in direct mode");

      // R5: latched parallel holds
      set_le(1'b0);
      @(negedge clk); par = 6'h01; idle(4);
      expect_code(6'h3A, "R5 held while strobe low");

      // R6: rising strobe captures
      @(negedge clk); par = 6'h11; idle(4);
      set_le(1'b1);
      expect_code(6'h11, "R6 capture on rising strobe");

      // R7: mode switch does not move code
      set_le(1'b0);
      @(negedge clk); mode = 1'b1; par = 6'h22; idle(4);
      expect_code(6'h11, "R7 hold across mode switch");
      send_bits(16'b000011, 6);
      expect_code(6'h11, "R7 hold before commit");
      set_le(1'b1);
      expect_code(6'h03, "R7 serial commit after switch");
      check_pulses("R8 total pulses");

      // R1: reset returns to maximum regardless of pins
      @(negedge clk); rst_n = 1'b0; mode = 1'b0; par = 6'h05; idle(3);
      check(code == 6'h3F, "R1 mid-run reset", code, 6'h3F);
      last_exp = 6'h3F;
      @(negedge clk); rst_n = 1'b1;
      expect_code(6'h05, "R4 direct after reset");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule